// File: doc/BRIEF.md
# Shadowed Nonvolatile RAM Controller

This block holds a byte-wide static RAM paired word for word with a nonvolatile shadow array, in a fully synchronous form. Four active-low enables (chip, output, write, nonvolatile) select one of several modes: RAM read, RAM write, whole-array recall (shadow into RAM), whole-array store (RAM into shadow), or idle. A bulk copy moves one word per clock. The `busy` flag stays high for a configurable number of cycles, and the host is locked out for that whole time.

Several guards protect the shadow array. A store or recall request must be held for a minimum number of consecutive cycles before it starts. A store is refused unless the RAM has been written since the last store or since power-up. A supply-low sense input freezes everything while it is high. When power-good rises, a full recall starts on its own. RAM access opens after a short power-up delay, and host-requested nonvolatile operations open after a longer one. The bidirectional data bus is split into `wr_data`, `rd_data` and a drive-enable output.

Top module: `nvsram_ctrl`

## Requirements
- R1: With `ce_n`=0, `oe_n`=0, `we_n`=1 and `nv_n`=1 sampled at a clock edge, and access allowed, `rd_data` shows the RAM word at `addr` and `rd_drive` is 1 in the following cycle.
- R2: With `ce_n`=0, `we_n`=0, `nv_n`=1 and `oe_n`=1 sampled at an edge, and access allowed, `wr_data` is written to `addr`. The same inputs with `oe_n`=0 write nothing.
- R3: `rd_drive` is 0 after reset, and in any cycle that does not follow an accepted read (chip or output enable high, nonvolatile enable low, or access refused).
- R4: Holding `ce_n`=0, `we_n`=0, `nv_n`=0, `oe_n`=1 for FILT_CYC consecutive edges starts a store at the last of those edges. `busy` is then high for STORE_CYC cycles, and every RAM word is copied into the shadow array.
- R5: Holding `ce_n`=0, `nv_n`=0, `oe_n`=0, `we_n`=1 for FILT_CYC consecutive edges starts a recall. `busy` is then high for RECALL_CYC cycles, and every shadow word is copied into the RAM.
- R6: A store or recall combination held for fewer than FILT_CYC consecutive edges starts nothing.
- R7: A store request is ignored unless at least one RAM write has been accepted since the last store began or since power-good last rose.
- R8: All four enables low does nothing. `nv_n`=0 with `we_n`=1 and `oe_n`=1 does nothing.
- R9: The edge at which `pwr_good` is first sampled high starts a full recall, whatever the control inputs are.
- R10: RAM reads and writes are ignored until PU_RAM_CYC edges have passed with `pwr_good` high. Host store and recall requests are ignored until PU_NV_CYC edges have passed.
- R11: While `busy` is high, every host read, write, store and recall is ignored.
- R12: While `vlow` is high, host operations are ignored and a running copy is paused. Each paused edge lengthens `busy` by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply valid; its rise triggers the automatic recall |
| vlow | input | 1 | Supply-low sense; inhibits all operations while high |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| nv_n | input | 1 | Nonvolatile enable, active low |
| addr | input | ADDR_W | Word address |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data |
| rd_drive | output | 1 | Read data bus drive enable |
| busy | output | 1 | High while a bulk copy is running |

## Verification
The mode decoder is driven with random mixes of reads, writes, writes with output enable low, chip-deselected cycles, all-enables-low and nonvolatile no-op cycles. These runs separate genuine RAM accesses from look-alike combinations that must leave both the RAM and the output driver untouched. Directed sequences then hold store and recall combinations for exactly the filter width and for one cycle less, which tells a started copy from a rejected glitch. The same directed style repeats store requests with and without a preceding write, and probes accesses inside each power-up window. A full-array read sweep after a store and a recall shows that both copies moved every word. A recall paused by supply-low and a store interrupted by a host write show that the busy length and the RAM contents respond only to the allowed events.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  typedef enum logic [1:0] {
    NV_NONE   = 2'd0,
    NV_STORE  = 2'd1,
    NV_RECALL = 2'd2
  } nv_req_e;

  typedef enum logic [1:0] {
    CP_IDLE   = 2'd0,
    CP_RECALL = 2'd1,
    CP_STORE  = 2'd2
  } copy_st_e;

  typedef struct packed {
    logic    rd;
    logic    wr;
    nv_req_e nv;
  } host_cmd_t;

  function automatic host_cmd_t decode_ctl(input logic ce_n, input logic oe_n,
                                           input logic we_n, input logic nv_n);
    host_cmd_t c;
    c.rd = !ce_n && !oe_n &&  we_n &&  nv_n;
    c.wr = !ce_n &&  oe_n && !we_n &&  nv_n;
    if (!ce_n && !nv_n && !we_n && oe_n)
      c.nv = NV_STORE;
    else if (!ce_n && !nv_n && we_n && !oe_n)
      c.nv = NV_RECALL;
    else
      c.nv = NV_NONE;
    return c;
  endfunction

endpackage

// File: rtl/nvs_powerup.sv
module nvs_powerup #(
  parameter int PU_RAM_CYC = 650,
  parameter int PU_NV_CYC  = 750
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  output logic pg_rise,
  output logic ram_ready,
  output logic nv_ready
);

  localparam int PW = $clog2(PU_NV_CYC + 1);
  localparam logic [PW-1:0] RAM_LIM = PW'(PU_RAM_CYC);
  localparam logic [PW-1:0] NV_LIM  = PW'(PU_NV_CYC);

  logic          pg_q;
  logic [PW-1:0] pu_cnt_q, pu_cnt_d;

  always_comb begin
    pu_cnt_d = pu_cnt_q;
    if (!pwr_good)
      pu_cnt_d = '0;
    else if (pu_cnt_q != NV_LIM)
      pu_cnt_d = pu_cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q     <= 1'b0;
      pu_cnt_q <= '0;
    end else begin
      pg_q     <= pwr_good;
      pu_cnt_q <= pu_cnt_d;
    end
  end

  assign pg_rise   = pwr_good && !pg_q;
  assign ram_ready = pu_cnt_q >= RAM_LIM;
  assign nv_ready  = pu_cnt_q >= NV_LIM;

endmodule

// File: rtl/nvs_start_filter.sv
module nvs_start_filter
  import nvs_pkg::*;
#(
  parameter int FILT_CYC = 3
) (
  input  logic    clk,
  input  logic    rst_n,
  input  nv_req_e req,
  input  logic    allow,
  input  logic    wr_seen,
  output logic    go_store,
  output logic    go_recall
);

  localparam int FW = $clog2(FILT_CYC + 1);
  localparam logic [FW-1:0] FILT_C = FW'(FILT_CYC);

  nv_req_e       prev_q;
  nv_req_e       req_eff;
  logic [FW-1:0] cnt_q, cnt_d;
  logic          same, fire;

  always_comb begin
    req_eff = allow ? req : NV_NONE;
    same    = (req_eff == prev_q);
    if (req_eff == NV_NONE)
      cnt_d = '0;
    else if (!same)
      cnt_d = FW'(1);
    else if (cnt_q != FILT_C)
      cnt_d = cnt_q + 1'b1;
    else
      cnt_d = cnt_q;
    fire      = (cnt_d == FILT_C) && !(same && cnt_q == FILT_C);
    go_store  = fire && (req_eff == NV_STORE) && wr_seen;
    go_recall = fire && (req_eff == NV_RECALL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= NV_NONE;
      cnt_q  <= '0;
    end else begin
      prev_q <= req_eff;
      cnt_q  <= cnt_d;
    end
  end

  AST_STORE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    go_store |-> $past(req == NV_STORE)); // R6
  AST_RECALL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    go_recall |-> $past(req == NV_RECALL)); // R6

endmodule

// File: rtl/nvs_copy_seq.sv
module nvs_copy_seq
  import nvs_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int RECALL_CYC = 600,
  parameter int STORE_CYC  = 1200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              vlow,
  input  logic              start_recall,
  input  logic              start_store,
  output logic              busy,
  output logic              ram_cp_we,
  output logic              nv_cp_we,
  output logic [ADDR_W-1:0] cp_idx
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int MAXLEN = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int CW     = $clog2(MAXLEN + 1);
  localparam logic [CW-1:0] DEPTH_C  = CW'(DEPTH);
  localparam logic [CW-1:0] REC_LAST = CW'(RECALL_CYC - 1);
  localparam logic [CW-1:0] STO_LAST = CW'(STORE_CYC - 1);

  copy_st_e      st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] last;
  logic          in_copy;

  always_comb begin
    last = (st_q == CP_STORE) ? STO_LAST : REC_LAST;
    st_d  = st_q;
    cnt_d = cnt_q;
    if (!pwr_good) begin
      st_d  = CP_IDLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        CP_IDLE: begin
          cnt_d = '0;
          if (start_recall)
            st_d = CP_RECALL;
          else if (start_store)
            st_d = CP_STORE;
        end
        CP_RECALL, CP_STORE: begin
          if (!vlow) begin
            if (cnt_q == last) begin
              st_d  = CP_IDLE;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        default: begin
          st_d  = CP_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CP_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy      = (st_q != CP_IDLE);
  assign in_copy   = pwr_good && !vlow && (cnt_q < DEPTH_C);
  assign ram_cp_we = in_copy && (st_q == CP_RECALL);
  assign nv_cp_we  = in_copy && (st_q == CP_STORE);
  assign cp_idx    = cnt_q[ADDR_W-1:0];

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_recall || start_store) |-> !busy); // R11
  AST_PAUSE_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && vlow && pwr_good) |=> busy); // R12

endmodule

// File: rtl/nvs_arrays.sv
module nvs_arrays #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              ram_cp_we,
  input  logic              nv_cp_we,
  input  logic [ADDR_W-1:0] cp_idx,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_din,
  output logic [DATA_W-1:0] host_dout
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] ram [DEPTH];
  logic [DATA_W-1:0] shadow [DEPTH];

  always_ff @(posedge clk) begin
    if (ram_cp_we)
      ram[cp_idx] <= shadow[cp_idx];
    else if (host_we)
      ram[host_addr] <= host_din;
  end

  always_ff @(posedge clk) begin
    if (nv_cp_we)
      shadow[cp_idx] <= ram[cp_idx];
  end

  assign host_dout = ram[host_addr];

endmodule

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl
  import nvs_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int DATA_W     = 8,
  parameter int FILT_CYC   = 3,
  parameter int RECALL_CYC = 600,
  parameter int STORE_CYC  = 1200,
  parameter int PU_RAM_CYC = 650,
  parameter int PU_NV_CYC  = 750
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              vlow,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              nv_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_drive,
  output logic              busy
);

  host_cmd_t         cmd;
  logic              pg_rise, ram_ready, nv_ready;
  logic              host_ok, nv_allow, host_wr, host_rd;
  logic              go_store, go_recall, start_recall;
  logic              wr_seen_q, wr_seen_d;
  logic              ram_cp_we, nv_cp_we;
  logic [ADDR_W-1:0] cp_idx;
  logic [DATA_W-1:0] arr_dout;
  logic [DATA_W-1:0] dout_q;
  logic              drive_q;

  assign cmd      = decode_ctl(ce_n, oe_n, we_n, nv_n);
  assign host_ok  = pwr_good && ram_ready && !busy && !vlow;
  assign nv_allow = pwr_good && nv_ready && !busy && !vlow;
  assign host_wr  = cmd.wr && host_ok;
  assign host_rd  = cmd.rd && host_ok;
  assign start_recall = pg_rise || go_recall;

  nvs_powerup #(
    .PU_RAM_CYC(PU_RAM_CYC),
    .PU_NV_CYC (PU_NV_CYC)
  ) u_pwr (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_good (pwr_good),
    .pg_rise  (pg_rise),
    .ram_ready(ram_ready),
    .nv_ready (nv_ready)
  );

  nvs_start_filter #(
    .FILT_CYC(FILT_CYC)
  ) u_filt (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (cmd.nv),
    .allow    (nv_allow),
    .wr_seen  (wr_seen_q),
    .go_store (go_store),
    .go_recall(go_recall)
  );

  nvs_copy_seq #(
    .ADDR_W    (ADDR_W),
    .RECALL_CYC(RECALL_CYC),
    .STORE_CYC (STORE_CYC)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_good    (pwr_good),
    .vlow        (vlow),
    .start_recall(start_recall),
    .start_store (go_store),
    .busy        (busy),
    .ram_cp_we   (ram_cp_we),
    .nv_cp_we    (nv_cp_we),
    .cp_idx      (cp_idx)
  );

  nvs_arrays #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_arr (
    .clk      (clk),
    .ram_cp_we(ram_cp_we),
    .nv_cp_we (nv_cp_we),
    .cp_idx   (cp_idx),
    .host_we  (host_wr),
    .host_addr(addr),
    .host_din (wr_data),
    .host_dout(arr_dout)
  );

  always_comb begin
    wr_seen_d = wr_seen_q;
    if (!pwr_good || go_store)
      wr_seen_d = 1'b0;
    else if (host_wr)
      wr_seen_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_seen_q <= 1'b0;
      drive_q   <= 1'b0;
      dout_q    <= '0;
    end else begin
      wr_seen_q <= wr_seen_d;
      drive_q   <= host_rd;
      if (host_rd)
        dout_q <= arr_dout;
    end
  end

  assign rd_data  = dout_q;
  assign rd_drive = drive_q;

  AST_DRIVE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_drive |-> $past(!ce_n && !oe_n && we_n && nv_n)); // R3
  AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !rd_drive); // R11
  AST_STORE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    go_store |-> wr_seen_q); // R7
  AST_VLOW_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    vlow |=> !rd_drive); // R12

endmodule

// File: tb/tb_nvsram_ctrl.sv
module tb_nvsram_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 9;
  localparam int DATA_W     = 8;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int FILT_CYC   = 3;
  localparam int RECALL_CYC = 600;
  localparam int STORE_CYC  = 1200;
  localparam int PU_RAM_CYC = 650;
  localparam int PU_NV_CYC  = 750;

  logic              clk = 1'b0;
  logic              rst_n, pwr_good, vlow;
  logic              ce_n, oe_n, we_n, nv_n;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;
  logic              rd_drive, busy;

  logic [DATA_W-1:0] m_ram [DEPTH];
  logic [DATA_W-1:0] m_nv  [DEPTH];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvsram_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FILT_CYC(FILT_CYC),
    .RECALL_CYC(RECALL_CYC), .STORE_CYC(STORE_CYC),
    .PU_RAM_CYC(PU_RAM_CYC), .PU_NV_CYC(PU_NV_CYC)
  ) dut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .vlow(vlow),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .nv_n(nv_n),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .rd_drive(rd_drive), .busy(busy)
  );

  function automatic logic [3:0] ctl_code(input int kind);
    // order: ce_n, oe_n, we_n, nv_n
    case (kind)
      0: return 4'b0011; // read
      1: return 4'b0101; // write
      2: return 4'b0001; // write with output enable low
      3: return 4'b0100; // store
      4: return 4'b0010; // recall
      5: return 4'b0000; // all low
      6: return 4'b0110; // nonvolatile no-op
      default: return 4'b1111;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(input int kind, input int a, input logic [DATA_W-1:0] d);
    logic [3:0] c;
    c = ctl_code(kind);
    {ce_n, oe_n, we_n, nv_n} = c;
    addr    = ADDR_W'(a);
    wr_data = d;
  endtask

  task automatic idle();
    drive(7, 0, '0);
  endtask

  task automatic do_write(input int a, input logic [DATA_W-1:0] d);
    drive(1, a, d);
    @(negedge clk);
    idle();
  endtask

  task automatic do_read(input string tag, input int a, input logic [DATA_W-1:0] exp);
    drive(0, a, '0);
    @(negedge clk);
    chk(tag, {31'd0, rd_drive}, 32'd1);
    chk(tag, {24'd0, rd_data}, {24'd0, exp});
    idle();
  endtask

  task automatic hold(input int kind, input int cyc);
    drive(kind, 0, '0);
    repeat (cyc) @(negedge clk);
    idle();
  endtask

  task automatic run_busy(input int poke_at, input int vl_from, input int vl_len, output int n);
    n = 0;
    while (busy === 1'b1 && n < 5000) begin
      n++;
      if (n == poke_at) drive(1, 7, ~m_ram[7]);
      else idle();
      vlow = (n > vl_from) && (n <= vl_from + vl_len);
      @(negedge clk);
    end
    idle();
    vlow = 1'b0;
  endtask

  initial begin
    repeat (190000) @(negedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    int a;
    logic [DATA_W-1:0] d;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; pwr_good = 1'b0; vlow = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    chk("R3 reset drive", {31'd0, rd_drive}, 32'd0);
    chk("R3 reset busy", {31'd0, busy}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: power-good rise with a store combination present
    pwr_good = 1'b1;
    drive(3, 0, '0);
    @(negedge clk);
    idle();
    chk("R9 auto recall starts", {31'd0, busy}, 32'd1);
    run_busy(0, 0, 0, n);
    chk("R9 auto recall length", n, RECALL_CYC);

    // R10: RAM window still closed
    drive(0, 5, '0);
    @(negedge clk);
    chk("R10 early read ignored", {31'd0, rd_drive}, 32'd0);
    idle();
    repeat (60) @(negedge clk);
    do_write(5, 8'h3C);
    m_ram[5] = 8'h3C;
    do_read("R2 write readback", 5, 8'h3C);
    hold(3, FILT_CYC);
    chk("R10 early store ignored", {31'd0, busy}, 32'd0);
    repeat (100) @(negedge clk);

    // fill the RAM so every word is known
    for (int i = 0; i < DEPTH; i++) begin
      d = 8'($urandom);
      do_write(i, d);
      m_ram[i] = d;
    end

    // random mix of host operations
    for (int i = 0; i < 400; i++) begin
      int k;
      k = $urandom_range(0, 7);
      a = $urandom_range(0, DEPTH - 1);
      d = 8'($urandom);
      if (k == 0) begin
        do_read("R1 random read", a, m_ram[a]);
      end else begin
        if (k == 3 || k == 4) k = 7;
        drive(k, a, d);
        @(negedge clk);
        if (k == 1) m_ram[a] = d;
        chk("R3 no drive without read", {31'd0, rd_drive}, 32'd0);
        idle();
      end
    end
    for (int i = 0; i < 16; i++) do_read("R2 R8 after random mix", i * 31, m_ram[i * 31]);

    // R4 store with a write attempt during busy (R11)
    hold(3, FILT_CYC);
    chk("R4 store starts", {31'd0, busy}, 32'd1);
    run_busy(10, 0, 0, n);
    chk("R4 store length", n, STORE_CYC);
    for (int i = 0; i < DEPTH; i++) m_nv[i] = m_ram[i];
    do_read("R11 write during busy ignored", 7, m_ram[7]);
    hold(3, FILT_CYC);
    chk("R7 store without write ignored", {31'd0, busy}, 32'd0);

    // scribble over RAM, then recall with a supply-low pause
    for (int i = 0; i < 64; i++) begin
      a = $urandom_range(0, DEPTH - 1);
      d = 8'($urandom);
      do_write(a, d);
      m_ram[a] = d;
    end
    hold(4, FILT_CYC);
    chk("R5 recall starts", {31'd0, busy}, 32'd1);
    run_busy(0, 20, 50, n);
    chk("R12 paused recall length", n, RECALL_CYC + 50);
    for (int i = 0; i < DEPTH; i++) m_ram[i] = m_nv[i];
    for (int i = 0; i < DEPTH; i++) do_read("R4 R5 sweep", i, m_ram[i]);

    // R6 glitch rejection
    do_write(9, 8'h5A);
    m_ram[9] = 8'h5A;
    hold(3, FILT_CYC - 1);
    repeat (2) @(negedge clk);
    chk("R6 short store", {31'd0, busy}, 32'd0);
    hold(4, FILT_CYC - 1);
    repeat (2) @(negedge clk);
    chk("R6 short recall", {31'd0, busy}, 32'd0);
    hold(3, FILT_CYC - 1);
    hold(4, 1);
    hold(3, FILT_CYC - 1);
    repeat (2) @(negedge clk);
    chk("R6 alternating short requests", {31'd0, busy}, 32'd0);
    do_read("R6 RAM untouched", 9, 8'h5A);

    // R8 illegal and no-op combinations
    drive(5, 9, 8'hFF);
    repeat (FILT_CYC + 2) @(negedge clk);
    chk("R8 all low no busy", {31'd0, busy}, 32'd0);
    chk("R8 all low no drive", {31'd0, rd_drive}, 32'd0);
    drive(6, 9, 8'h11);
    repeat (FILT_CYC + 2) @(negedge clk);
    chk("R8 no-op no busy", {31'd0, busy}, 32'd0);
    chk("R8 no-op no drive", {31'd0, rd_drive}, 32'd0);
    idle();
    do_read("R8 RAM unchanged", 9, 8'h5A);

    // R12 supply-low blocks host access
    vlow = 1'b1;
    do_write(9, 8'hC3);
    drive(0, 9, '0);
    @(negedge clk);
    chk("R12 read blocked", {31'd0, rd_drive}, 32'd0);
    hold(4, FILT_CYC + 1);
    chk("R12 recall blocked", {31'd0, busy}, 32'd0);
    vlow = 1'b0;
    @(negedge clk);
    do_read("R12 write blocked", 9, 8'h5A);

    // power cycle: automatic recall restores shadow contents
    pwr_good = 1'b0;
    repeat (5) @(negedge clk);
    pwr_good = 1'b1;
    @(negedge clk);
    chk("R9 second auto recall", {31'd0, busy}, 32'd1);
    run_busy(0, 0, 0, n);
    chk("R9 second recall length", n, RECALL_CYC);
    for (int i = 0; i < DEPTH; i++) m_ram[i] = m_nv[i];
    repeat (PU_NV_CYC) @(negedge clk);
    for (int i = 0; i < 24; i++) do_read("R9 restored word", i * 21, m_ram[i * 21]);
    hold(3, FILT_CYC);
    chk("R7 no write since power-up", {31'd0, busy}, 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule